// File: doc/BRIEF.md
# Seconds Counter with Alarm and Interrupt Registers

This block is the register-side core of a real-time clock. It keeps a 32-bit count of seconds that software can load at any time, and a 32-bit alarm value that is compared against that count. A separate tick generator supplies a one-cycle strobe once per second and its current sub-second tick count. The core itself contains no oscillator and no calibration logic. It only stores a calibration word and a pair of control enables, and it drives them out to the blocks that use them.

Two events are recorded in a status register: the per-second event and the alarm event. Software clears them by writing ones back to that register. A per-source enable state decides which recorded events reach the two interrupt lines. That state is never written directly. It is changed only through a set register and a clear register. The bus is a plain single-cycle register port: a write is taken at the clock edge while `bus_wr` is high, and `bus_rdata` follows `bus_addr` combinationally. Status bit 0 is the seconds event and bit 1 is the alarm event in every interrupt-related register.

Top module: `rtc_sec_core`

## Requirements
- R1: While `rst_n` is low and after its release, the seconds (0x10), alarm (0x18), status (0x20), enabled view (0x24), calibration readback (0x0C) and control (0x40) registers read zero, and both interrupt lines are low.
- R2: A write to 0x00 sets the seconds count to the written value at that clock edge, and 0x04 returns the value most recently written to 0x00.
- R3: At each edge where `sec_strobe` is high and no load is written, the seconds count at 0x10 rises by one, and it wraps from 0xFFFFFFFF to 0. A load in the same cycle takes precedence over the strobe. Without either, the count holds.
- R4: Status bit 0 is set at the edge that ends any cycle with `sec_strobe` high, whatever the enable state.
- R5: Status bit 1 is set one edge after the seconds count first becomes equal to the alarm value (0x18, readable and writable). It fires once per match and does not fire again while the two stay equal.
- R6: Writing 0x20 clears each status bit written as 1 and leaves bits written as 0 unchanged. An event arriving in the same cycle as its clear leaves the bit set.
- R7: Writing a 1 to bit n of 0x28 enables source n, and writing a 1 to bit n of 0x2C disables it. Zero bits change nothing. 0x24 shows 1 for each enabled source, and 0x28 and 0x2C read as 0.
- R8: `irq_sec` equals status bit 0 AND enable bit 0, and `irq_alarm` equals status bit 1 AND enable bit 1.
- R9: 0x14 returns `tick_count` zero-extended to 32 bits.
- R10: Control register 0x40 keeps bit 31, which drives `batt_enable`, and bit 24, which drives `osc_enable`. Both read back as written, and all other bits read 0.
- R11: A write to 0x08 keeps the low 21 bits, which drive `calib_value` and read back at 0x0C. 0x08 itself reads 0.
- R12: Reads of 0x00 and of unmapped addresses such as 0x30 return 0. Writes to unmapped addresses change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, taken at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| sec_strobe | input | 1 | One-cycle pulse once per second from the tick generator |
| tick_count | input | TICK_W | Sub-second tick count from the tick generator |
| calib_value | output | CAL_W | Stored calibration word |
| osc_enable | output | 1 | Oscillator enable control bit |
| batt_enable | output | 1 | Battery-switch enable control bit |
| irq_sec | output | 1 | Seconds interrupt line |
| irq_alarm | output | 1 | Alarm interrupt line |

## Verification
A wrong seconds count is visible at 0x10 in the very cycle after the faulty edge, because the bench reads the count after every load and strobe and compares it with an arithmetic model, including the wrap. A lost or duplicated alarm match shows at status bit 1 exactly one edge after equality, and the bench samples both before and after that edge. Corrupt enable or status state reaches the interrupt lines directly. The bench therefore sweeps all sixteen combinations of status and enable and checks both lines and both registers after each one.

// File: rtl/rtc_sec_pkg.sv
`timescale 1ns/1ps
package rtc_sec_pkg;
    localparam int unsigned DATA_W = 32;

    localparam logic [7:0] OFS_LOAD_WR  = 8'h00;
    localparam logic [7:0] OFS_LOAD_RD  = 8'h04;
    localparam logic [7:0] OFS_CAL_WR   = 8'h08;
    localparam logic [7:0] OFS_CAL_RD   = 8'h0C;
    localparam logic [7:0] OFS_SECONDS  = 8'h10;
    localparam logic [7:0] OFS_TICK     = 8'h14;
    localparam logic [7:0] OFS_ALARM    = 8'h18;
    localparam logic [7:0] OFS_STATUS   = 8'h20;
    localparam logic [7:0] OFS_ENA_VIEW = 8'h24;
    localparam logic [7:0] OFS_ENA_SET  = 8'h28;
    localparam logic [7:0] OFS_ENA_CLR  = 8'h2C;
    localparam logic [7:0] OFS_CONTROL  = 8'h40;

    localparam int unsigned CTRL_BATT_BIT = 31;
    localparam int unsigned CTRL_OSC_BIT  = 24;

    localparam int unsigned NSRC     = 2;
    localparam int unsigned SRC_SEC  = 0;
    localparam int unsigned SRC_ALRM = 1;

    typedef struct packed {
        logic load;
        logic alarm;
        logic calib;
        logic status;
        logic ena_set;
        logic ena_clr;
        logic control;
    } wr_sel_t;

    typedef enum logic [3:0] {
        RD_NONE,
        RD_LOAD,
        RD_CAL,
        RD_SECONDS,
        RD_TICK,
        RD_ALARM,
        RD_STATUS,
        RD_ENA,
        RD_CONTROL
    } rd_sel_e;
endpackage

// File: rtl/rtc_reg_decode.sv
`timescale 1ns/1ps
module rtc_reg_decode
    import rtc_sec_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    output wr_sel_t           wsel,
    output rd_sel_e           rsel
);
    function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] ofs);
        return a == ADDR_W'(ofs);
    endfunction

    always_comb begin
        wsel         = '0;
        wsel.load    = wr && hit(addr, OFS_LOAD_WR);
        wsel.alarm   = wr && hit(addr, OFS_ALARM);
        wsel.calib   = wr && hit(addr, OFS_CAL_WR);
        wsel.status  = wr && hit(addr, OFS_STATUS);
        wsel.ena_set = wr && hit(addr, OFS_ENA_SET);
        wsel.ena_clr = wr && hit(addr, OFS_ENA_CLR);
        wsel.control = wr && hit(addr, OFS_CONTROL);
    end

    always_comb begin
        rsel = RD_NONE;
        if (hit(addr, OFS_LOAD_RD))  rsel = RD_LOAD;
        if (hit(addr, OFS_CAL_RD))   rsel = RD_CAL;
        if (hit(addr, OFS_SECONDS))  rsel = RD_SECONDS;
        if (hit(addr, OFS_TICK))     rsel = RD_TICK;
        if (hit(addr, OFS_ALARM))    rsel = RD_ALARM;
        if (hit(addr, OFS_STATUS))   rsel = RD_STATUS;
        if (hit(addr, OFS_ENA_VIEW)) rsel = RD_ENA;
        if (hit(addr, OFS_CONTROL))  rsel = RD_CONTROL;
    end
endmodule

// File: rtl/rtc_sec_counter.sv
`timescale 1ns/1ps
module rtc_sec_counter #(
    parameter int SEC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_we,
    input  logic [SEC_W-1:0] load_val,
    input  logic             alarm_we,
    input  logic [SEC_W-1:0] alarm_val,
    input  logic             strobe,
    output logic [SEC_W-1:0] count,
    output logic [SEC_W-1:0] alarm,
    output logic [SEC_W-1:0] load_shadow,
    output logic             alarm_evt
);
    typedef struct packed {
        logic [SEC_W-1:0] cnt;
        logic [SEC_W-1:0] alm;
        logic [SEC_W-1:0] shadow;
        logic             eq;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic       eq_now;

    always_comb begin
        st_d      = st_q;
        eq_now    = (st_q.cnt == st_q.alm);
        alarm_evt = eq_now && !st_q.eq;
        st_d.eq   = eq_now;
        if (load_we) begin
            st_d.cnt    = load_val;
            st_d.shadow = load_val;
        end else if (strobe) begin
            st_d.cnt = st_q.cnt + SEC_W'(1);
        end
        if (alarm_we) begin
            st_d.alm = alarm_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt    <= '0;
            st_q.alm    <= '0;
            st_q.shadow <= '0;
            st_q.eq     <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign count       = st_q.cnt;
    assign alarm       = st_q.alm;
    assign load_shadow = st_q.shadow;

    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        load_we |=> (count == $past(load_val)) && (load_shadow == $past(load_val))); // R2
    AST_STROBE_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !load_we) |=> count == SEC_W'($past(count) + SEC_W'(1))); // R3
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe && !load_we) |=> $stable(count)); // R3
    AST_ALARM_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_evt |=> !alarm_evt); // R5
endmodule

// File: rtl/rtc_irq_ctrl.sv
`timescale 1ns/1ps
module rtc_irq_ctrl #(
    parameter int NSRC = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] evt,
    input  logic            clr_we,
    input  logic            ena_set_we,
    input  logic            ena_clr_we,
    input  logic [NSRC-1:0] wbits,
    output logic [NSRC-1:0] status,
    output logic [NSRC-1:0] enable,
    output logic [NSRC-1:0] irq
);
    typedef struct packed {
        logic [NSRC-1:0] sts;
        logic [NSRC-1:0] ena;
    } irq_state_t;

    irq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NSRC; i++) begin
            if (evt[i]) begin
                st_d.sts[i] = 1'b1;
            end else if (clr_we && wbits[i]) begin
                st_d.sts[i] = 1'b0;
            end
            if (ena_set_we && wbits[i]) begin
                st_d.ena[i] = 1'b1;
            end else if (ena_clr_we && wbits[i]) begin
                st_d.ena[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status = st_q.sts;
    assign enable = st_q.ena;

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        assign irq[g] = st_q.sts[g] & st_q.ena[g];

        AST_EVT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
            evt[g] |=> status[g]); // R4
        AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_we && wbits[g] && !evt[g]) |=> !status[g]); // R6
        AST_ENA_SETS: assert property (@(posedge clk) disable iff (!rst_n)
            (ena_set_we && wbits[g]) |=> enable[g]); // R7
        AST_ENA_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (ena_clr_we && wbits[g]) |=> !enable[g]); // R7
        AST_ENA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (!ena_set_we && !ena_clr_we) |=> $stable(enable[g])); // R7
    end
endmodule

// File: rtl/rtc_sec_core.sv
`timescale 1ns/1ps
module rtc_sec_core
    import rtc_sec_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int SEC_W  = 32,
    parameter int TICK_W = 16,
    parameter int CAL_W  = 21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              sec_strobe,
    input  logic [TICK_W-1:0] tick_count,
    output logic [CAL_W-1:0]  calib_value,
    output logic              osc_enable,
    output logic              batt_enable,
    output logic              irq_sec,
    output logic              irq_alarm
);
    localparam int unsigned W = DATA_W;

    typedef struct packed {
        logic [CAL_W-1:0] cal;
        logic             osc;
        logic             batt;
    } cfg_state_t;

    wr_sel_t         wsel;
    rd_sel_e         rsel;
    logic [SEC_W-1:0] cnt, alm, shadow;
    logic            alarm_evt;
    logic [NSRC-1:0] evt, status, enable, irq;
    cfg_state_t      cfg_d, cfg_q;

    rtc_reg_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .wr   (bus_wr),
        .wsel (wsel),
        .rsel (rsel)
    );

    rtc_sec_counter #(.SEC_W(SEC_W)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_we     (wsel.load),
        .load_val    (bus_wdata[SEC_W-1:0]),
        .alarm_we    (wsel.alarm),
        .alarm_val   (bus_wdata[SEC_W-1:0]),
        .strobe      (sec_strobe),
        .count       (cnt),
        .alarm       (alm),
        .load_shadow (shadow),
        .alarm_evt   (alarm_evt)
    );

    always_comb begin
        evt           = '0;
        evt[SRC_SEC]  = sec_strobe;
        evt[SRC_ALRM] = alarm_evt;
    end

    rtc_irq_ctrl #(.NSRC(NSRC)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt        (evt),
        .clr_we     (wsel.status),
        .ena_set_we (wsel.ena_set),
        .ena_clr_we (wsel.ena_clr),
        .wbits      (bus_wdata[NSRC-1:0]),
        .status     (status),
        .enable     (enable),
        .irq        (irq)
    );

    always_comb begin
        cfg_d = cfg_q;
        if (wsel.calib) begin
            cfg_d.cal = bus_wdata[CAL_W-1:0];
        end
        if (wsel.control) begin
            cfg_d.osc  = bus_wdata[CTRL_OSC_BIT];
            cfg_d.batt = bus_wdata[CTRL_BATT_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (rsel)
            RD_LOAD:    bus_rdata = W'(shadow);
            RD_CAL:     bus_rdata = W'(cfg_q.cal);
            RD_SECONDS: bus_rdata = W'(cnt);
            RD_TICK:    bus_rdata = W'(tick_count);
            RD_ALARM:   bus_rdata = W'(alm);
            RD_STATUS:  bus_rdata = W'(status);
            RD_ENA:     bus_rdata = W'(enable);
            RD_CONTROL: begin
                bus_rdata[CTRL_OSC_BIT]  = cfg_q.osc;
                bus_rdata[CTRL_BATT_BIT] = cfg_q.batt;
            end
            default:    bus_rdata = '0;
        endcase
    end

    assign calib_value = cfg_q.cal;
    assign osc_enable  = cfg_q.osc;
    assign batt_enable = cfg_q.batt;
    assign irq_sec     = irq[SRC_SEC];
    assign irq_alarm   = irq[SRC_ALRM];

    AST_CTRL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !wsel.control |=> $stable(osc_enable) && $stable(batt_enable)); // R10
    AST_CAL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !wsel.calib |=> $stable(calib_value)); // R11
    AST_CAL_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        wsel.calib |=> calib_value == $past(bus_wdata[CAL_W-1:0])); // R11
endmodule

// File: tb/sim_rtc_sec_core.sv
`timescale 1ns/1ps
module sim_rtc_sec_core;
    localparam logic [7:0] A_LOAD = 8'h00, A_LOADRD = 8'h04, A_CALW = 8'h08, A_CALR = 8'h0C;
    localparam logic [7:0] A_SEC = 8'h10, A_TICK = 8'h14, A_ALM = 8'h18, A_STS = 8'h20;
    localparam logic [7:0] A_ENV = 8'h24, A_ENS = 8'h28, A_ENC = 8'h2C, A_CTL = 8'h40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic        wr = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        strobe = 1'b0;
    logic [15:0] tick = '0;
    logic [20:0] calib;
    logic        osc, batt, irq_s, irq_a;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    logic [31:0] model_cnt = '0;

    always #5 clk = ~clk;

    rtc_sec_core u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_wdata(wdata),
        .bus_rdata(rdata), .sec_strobe(strobe), .tick_count(tick), .calib_value(calib),
        .osc_enable(osc), .batt_enable(batt), .irq_sec(irq_s), .irq_alarm(irq_a)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d, input logic stb);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1; strobe = stb;
        @(negedge clk);
        wr = 1'b0; strobe = 1'b0;
    endtask

    task automatic pulse;
        @(negedge clk);
        strobe = 1'b1;
        @(negedge clk);
        strobe = 1'b0;
        model_cnt = model_cnt + 32'd1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic read_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        addr = a;
        #1;
        check(req, rdata, exp);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog R1 act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        idle(3);
        // R1 reset state, during and after reset
        read_chk("R1 sec in reset", A_SEC, 32'h0);
        rst_n = 1'b1;
        idle(1);
        read_chk("R1 sec", A_SEC, 32'h0);
        read_chk("R1 alarm", A_ALM, 32'h0);
        read_chk("R1 status", A_STS, 32'h0);
        read_chk("R1 enable view", A_ENV, 32'h0);
        read_chk("R1 calib", A_CALR, 32'h0);
        read_chk("R1 control", A_CTL, 32'h0);
        check("R1 irq lines", {30'h0, irq_a, irq_s}, 32'h0);

        // R2 load
        bus_write(A_LOAD, 32'h1234_5678, 1'b0);
        model_cnt = 32'h1234_5678;
        read_chk("R2 load value", A_SEC, model_cnt);
        read_chk("R2 load readback", A_LOADRD, 32'h1234_5678);
        idle(2);
        read_chk("R3 hold without strobe", A_SEC, model_cnt);

        // R3 wrap and load precedence
        bus_write(A_LOAD, 32'hFFFF_FFFE, 1'b0);
        model_cnt = 32'hFFFF_FFFE;
        pulse();
        read_chk("R3 step to max", A_SEC, 32'hFFFF_FFFF);
        pulse();
        read_chk("R3 wrap to zero", A_SEC, 32'h0);
        bus_write(A_LOAD, 32'd50, 1'b1);
        model_cnt = 32'd50;
        read_chk("R3 load beats strobe", A_SEC, 32'd50);
        read_chk("R2 readback after precedence", A_LOADRD, 32'd50);
        for (int k = 0; k < 20; k++) begin
            pulse();
            read_chk("R3 count sweep", A_SEC, model_cnt);
        end

        // R4 seconds event with sources disabled
        bus_write(A_STS, 32'h3, 1'b0);
        read_chk("R6 clear all", A_STS, 32'h0);
        pulse();
        read_chk("R4 sec event latched", A_STS, 32'h1);
        check("R8 irq_sec disabled", {31'h0, irq_s}, 32'h0);

        // R5 alarm timing
        bus_write(A_STS, 32'h3, 1'b0);
        bus_write(A_ALM, model_cnt + 32'd2, 1'b0);
        read_chk("R5 alarm readback", A_ALM, model_cnt + 32'd2);
        pulse();
        read_chk("R5 not yet equal", A_STS, 32'h1);
        pulse();
        read_chk("R5 no set on equal edge", A_STS, 32'h1);
        idle(1);
        read_chk("R5 set one edge later", A_STS, 32'h3);
        bus_write(A_STS, 32'h2, 1'b0);
        read_chk("R6 clear bit1 only", A_STS, 32'h1);
        idle(3);
        read_chk("R5 once per match", A_STS, 32'h1);

        // R6 zero bits, set beats clear
        bus_write(A_STS, 32'h0, 1'b0);
        read_chk("R6 zero write no effect", A_STS, 32'h1);
        bus_write(A_STS, 32'h1, 1'b1);
        model_cnt = model_cnt + 32'd1;
        read_chk("R6 event beats clear", A_STS, 32'h1);
        bus_write(A_STS, 32'h1, 1'b0);
        read_chk("R6 clear bit0", A_STS, 32'h0);

        // R7 and R8 sweep of status x enable
        for (int s = 0; s < 4; s++) begin
            for (int m = 0; m < 4; m++) begin
                bus_write(A_ALM, 32'd5, 1'b0);
                bus_write(A_LOAD, 32'd1000, 1'b0);
                model_cnt = 32'd1000;
                bus_write(A_STS, 32'h3, 1'b0);
                bus_write(A_ENC, 32'h3, 1'b0);
                bus_write(A_ENS, m, 1'b0);
                if (s[1]) begin
                    bus_write(A_ALM, 32'd1000, 1'b0);
                    idle(1);
                end
                if (s[0]) pulse();
                read_chk("R4 R5 sweep status", A_STS, s);
                read_chk("R7 sweep enable view", A_ENV, m);
                check("R8 sweep irq lines", {30'h0, irq_a, irq_s}, s & m);
                read_chk("R3 sweep count", A_SEC, model_cnt);
            end
        end
        bus_write(A_ENC, 32'h3, 1'b0);
        bus_write(A_ENS, 32'h2, 1'b0);
        bus_write(A_ENS, 32'h0, 1'b0);
        read_chk("R7 zero set no effect", A_ENV, 32'h2);
        bus_write(A_ENC, 32'h0, 1'b0);
        read_chk("R7 zero clear no effect", A_ENV, 32'h2);
        read_chk("R7 set reg reads zero", A_ENS, 32'h0);
        read_chk("R7 clear reg reads zero", A_ENC, 32'h0);

        // R9 tick pass-through
        for (int t = 0; t < 16; t++) begin
            tick = 16'(t * 4099 + 7);
            read_chk("R9 tick", A_TICK, {16'h0, tick});
        end

        // R10 control
        bus_write(A_CTL, 32'hFFFF_FFFF, 1'b0);
        read_chk("R10 control all ones", A_CTL, 32'h8100_0000);
        check("R10 outputs set", {30'h0, batt, osc}, 32'h3);
        bus_write(A_CTL, 32'h0100_0000, 1'b0);
        read_chk("R10 osc only", A_CTL, 32'h0100_0000);
        check("R10 outputs osc only", {30'h0, batt, osc}, 32'h1);

        // R11 calibration
        bus_write(A_CALW, 32'hFFFF_FFFF, 1'b0);
        check("R11 calib out", {11'h0, calib}, 32'h001F_FFFF);
        read_chk("R11 calib readback", A_CALR, 32'h001F_FFFF);
        read_chk("R11 calib write reads zero", A_CALW, 32'h0);
        bus_write(A_CALW, 32'h0019_8233, 1'b0);
        read_chk("R11 calib second value", A_CALR, 32'h0019_8233);

        // R12 unmapped and write-only
        bus_write(8'h30, 32'hDEAD_BEEF, 1'b0);
        read_chk("R12 unmapped read", 8'h30, 32'h0);
        read_chk("R12 load write reads zero", A_LOAD, 32'h0);
        read_chk("R12 count untouched", A_SEC, model_cnt);
        read_chk("R12 control untouched", A_CTL, 32'h0100_0000);
        read_chk("R12 calib untouched", A_CALR, 32'h0019_8233);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule